// File: doc/BRIEF.md
# Adder-Array Toggle Activity Monitor

This block watches an array of full adders, for example the cells of a small array multiplier, and measures how much of the array switches from one operation to the next. Each time a new operand pair has settled, the surrounding logic raises a strobe and presents the sum and carry-out of every adder on two flat buses. The monitor compares each adder's pair of outputs with the pair that the same adder produced for the previous accepted operation. It then forms a switching score in which an adder counts fully when both of its outputs flip and counts half when only one of them does.

The score is kept in half-toggle units so that the total stays an integer. A sequential restoring divider then turns the score into an activity factor: the switching total divided by the product of the two operand widths, given as an unsigned fixed-point number. A one-cycle done pulse marks each new factor. While the divider is working, a busy output is high and further strobes are dropped. The first operation after reset only fills the history and scores zero.

Top module: `adder_toggle_monitor`

## Requirements
- R1: During and directly after reset, `score`, `activity`, `done` and `busy` are all zero.
- R2: The first strobe accepted after reset loads the history from the buses and reports a score of zero and an activity of zero.
- R3: Adder i is bit i of `fa_sum` and bit i of `fa_cout`. An adder adds 2 half-toggle units when both of its outputs differ from its stored pair, 1 unit when exactly one differs, and 0 when neither differs.
- R4: `score` is the sum of the units of all adders, at most 2*NUM_FA, and never wraps.
- R5: The history changes only on an accepted strobe, so every score compares against the buses of the previous accepted strobe.
- R6: `activity` equals floor(score * 2^(FRAC_W-1) / (M_W*N_W)), i.e. the full-toggle total divided by M_W*N_W with FRAC_W fractional bits.
- R7: `done` is high for exactly one cycle, DW = SCORE_W+FRAC_W-1 clock edges after the edge that accepted the strobe (SCORE_W = ceil(log2(2*NUM_FA+1))); `activity` takes its new value in that same cycle.
- R8: `busy` is high from the cycle after acceptance until `done` rises; a strobe while `busy` is high changes neither the history, `score`, nor produces an extra `done`.
- R9: `score` holds its value from one accepted strobe until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Buses carry settled outputs of a new operation |
| fa_sum | input | NUM_FA | Sum output of each adder |
| fa_cout | input | NUM_FA | Carry-out of each adder |
| score | output | SCORE_W | Switching score of the last accepted operation, half-toggle units |
| activity | output | DW | Activity factor, FRAC_W fractional bits |
| done | output | 1 | One-cycle pulse when `activity` is new |
| busy | output | 1 | Division running; strobes are ignored |

## Verification
The bench builds the block with twelve adders, 4x4 operand widths and eight fractional bits, which matches a four-bit carry-save array. At that size, driving every adder's two outputs to flip reaches the largest score of 24 and an activity of 192. Single-adder flips show the half and full weights apart. Strobes held high during the twelve-cycle division, together with a reset in the middle of the run, exercise the drop rule and the zero score of a first operation.

// File: rtl/taf_pkg.sv
package taf_pkg;

  // Half-toggle units of one adder: one per output that flipped.
  function automatic logic [1:0] fa_half_toggles(
    input logic sum_now,
    input logic cout_now,
    input logic sum_old,
    input logic cout_old
  );
    logic s_flip;
    logic c_flip;
    s_flip = sum_now ^ sum_old;
    c_flip = cout_now ^ cout_old;
    return {s_flip & c_flip, s_flip ^ c_flip};
  endfunction

endpackage

// File: rtl/taf_toggle_scorer.sv
module taf_toggle_scorer #(
  parameter int NUM_FA  = 12,
  parameter int SCORE_W = 5
) (
  input  logic [NUM_FA-1:0]  now_sum,
  input  logic [NUM_FA-1:0]  now_cout,
  input  logic [NUM_FA-1:0]  old_sum,
  input  logic [NUM_FA-1:0]  old_cout,
  output logic [SCORE_W-1:0] total
);
  import taf_pkg::*;

  logic [1:0] cell_units [NUM_FA];

  for (genvar g = 0; g < NUM_FA; g++) begin : g_cell
    assign cell_units[g] = fa_half_toggles(now_sum[g], now_cout[g],
                                           old_sum[g], old_cout[g]);
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_FA; i++) begin
      total = total + SCORE_W'(cell_units[i]);
    end
  end

endmodule

// File: rtl/taf_seq_divider.sv
module taf_seq_divider #(
  parameter int DW  = 12,
  parameter int DVW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic [DW-1:0]  quotient,
  output logic           done,
  output logic           busy
);
  localparam int CW = $clog2(DW + 1);

  logic [DVW-1:0] rem_q, rem_d;
  logic [DW-1:0]  work_q, work_d;
  logic [DW-1:0]  res_q, res_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;

  logic [DVW:0]   rem_sh;
  logic           fits;
  logic [DW-1:0]  work_step;
  logic [DVW-1:0] rem_step;

  assign busy = (cnt_q != '0);

  always_comb begin
    rem_sh    = {rem_q, work_q[DW-1]};
    fits      = (rem_sh >= {1'b0, divisor});
    rem_step  = fits ? DVW'(rem_sh - {1'b0, divisor}) : rem_sh[DVW-1:0];
    work_step = {work_q[DW-2:0], fits};
  end

  always_comb begin
    rem_d  = rem_q;
    work_d = work_q;
    res_d  = res_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start && !busy) begin
      rem_d  = '0;
      work_d = dividend;
      cnt_d  = CW'(DW);
    end else if (busy) begin
      rem_d  = rem_step;
      work_d = work_step;
      cnt_d  = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        res_d  = work_step;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      work_q <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      work_q <= work_d;
      res_q  <= res_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign quotient = res_q;
  assign done     = done_q;

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);

  assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_d |=> $stable(res_q));

endmodule

// File: rtl/adder_toggle_monitor.sv
module adder_toggle_monitor #(
  parameter int NUM_FA  = 12,
  parameter int M_W     = 4,
  parameter int N_W     = 4,
  parameter int FRAC_W  = 8,
  localparam int SCORE_W = $clog2(2 * NUM_FA + 1),
  localparam int DW      = SCORE_W + FRAC_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_valid,
  input  logic [NUM_FA-1:0]  fa_sum,
  input  logic [NUM_FA-1:0]  fa_cout,
  output logic [SCORE_W-1:0] score,
  output logic [DW-1:0]      activity,
  output logic               done,
  output logic               busy
);
  localparam int PROD = M_W * N_W;
  localparam int DVW  = $clog2(PROD + 1);

  logic [NUM_FA-1:0]  hist_sum_q, hist_sum_d;
  logic [NUM_FA-1:0]  hist_cout_q, hist_cout_d;
  logic               primed_q, primed_d;
  logic [SCORE_W-1:0] score_q, score_d;
  logic [SCORE_W-1:0] raw_total;
  logic               div_busy;
  logic               accept;
  logic [DW-1:0]      dividend;

  taf_toggle_scorer #(.NUM_FA(NUM_FA), .SCORE_W(SCORE_W)) u_scorer (
    .now_sum  (fa_sum),
    .now_cout (fa_cout),
    .old_sum  (hist_sum_q),
    .old_cout (hist_cout_q),
    .total    (raw_total)
  );

  assign accept = sample_valid && !div_busy;

  always_comb begin
    hist_sum_d  = hist_sum_q;
    hist_cout_d = hist_cout_q;
    primed_d    = primed_q;
    score_d     = score_q;
    if (accept) begin
      hist_sum_d  = fa_sum;
      hist_cout_d = fa_cout;
      primed_d    = 1'b1;
      score_d     = primed_q ? raw_total : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_sum_q  <= '0;
      hist_cout_q <= '0;
      primed_q    <= 1'b0;
      score_q     <= '0;
    end else begin
      hist_sum_q  <= hist_sum_d;
      hist_cout_q <= hist_cout_d;
      primed_q    <= primed_d;
      score_q     <= score_d;
    end
  end

  assign dividend = DW'(score_d) << (FRAC_W - 1);

  taf_seq_divider #(.DW(DW), .DVW(DVW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .dividend (dividend),
    .divisor  (DVW'(PROD)),
    .quotient (activity),
    .done     (done),
    .busy     (div_busy)
  );

  assign busy  = div_busy;
  assign score = score_q;

  assert_first_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !busy && !primed_q) |=> (score == '0));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    score <= SCORE_W'(2 * NUM_FA));

  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_valid && !busy) |=> ($stable(hist_sum_q) && $stable(hist_cout_q)));

  assert_score_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_valid && !busy) |=> $stable(score));

endmodule

// File: tb/adder_toggle_monitor_tb.sv
module adder_toggle_monitor_tb;
  localparam int NUM_FA  = 12;
  localparam int M_W     = 4;
  localparam int N_W     = 4;
  localparam int FRAC_W  = 8;
  localparam int SCORE_W = $clog2(2 * NUM_FA + 1);
  localparam int DW      = SCORE_W + FRAC_W - 1;

  typedef struct {
    int score;
    int act;
    int acc_cyc;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample_valid = 1'b0;
  logic [NUM_FA-1:0] fa_sum = '0;
  logic [NUM_FA-1:0] fa_cout = '0;
  logic [SCORE_W-1:0] score;
  logic [DW-1:0]     activity;
  logic              done;
  logic              busy;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  exp_t exp_q[$];
  logic [NUM_FA-1:0] m_sum = '0;
  logic [NUM_FA-1:0] m_cout = '0;
  bit m_primed = 0;
  bit finished = 0;

  adder_toggle_monitor #(.NUM_FA(NUM_FA), .M_W(M_W), .N_W(N_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .fa_sum(fa_sum), .fa_cout(fa_cout),
    .score(score), .activity(activity), .done(done), .busy(busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: applies one operation and pushes its expected result.
  task automatic apply(input logic [NUM_FA-1:0] s, input logic [NUM_FA-1:0] c);
    exp_t e;
    int sc;
    sc = 0;
    if (m_primed) begin
      for (int i = 0; i < NUM_FA; i++) begin
        sc += int'(s[i] != m_sum[i]) + int'(c[i] != m_cout[i]);
      end
    end
    m_sum = s; m_cout = c; m_primed = 1;
    sample_valid = 1'b1; fa_sum = s; fa_cout = c;
    @(negedge clk);
    sample_valid = 1'b0;
    e.score = sc;
    e.act = (sc * (1 << (FRAC_W - 1))) / (M_W * N_W);
    e.acc_cyc = cyc;
    exp_q.push_back(e);
    check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // Monitor: pops expected results when done is seen.
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(score) == e.score, "R3/R4 score", int'(score), e.score);
          check(int'(activity) == e.act, "R6 activity", int'(activity), e.act);
          check(cyc - e.acc_cyc == DW, "R7 latency", cyc - e.acc_cyc, DW);
        end
        @(negedge clk);
        check(done == 1'b0, "R7 single pulse", int'(done), 0);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [SCORE_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(score == '0, "R1 score", int'(score), 0);
    check(activity == '0, "R1 activity", int'(activity), 0);
    check(done == 1'b0 && busy == 1'b0, "R1 done/busy", int'({done, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(score == '0 && busy == 1'b0, "R1 after release", int'(score), 0);

    // R2: first op scores zero
    apply(12'hA5C, 12'h3F0); wait_idle();
    // repeat: nothing toggles
    apply(12'hA5C, 12'h3F0); wait_idle();
    // R3: only sum of adder 0 flips -> 1
    apply(12'hA5D, 12'h3F0); wait_idle();
    // R3: both outputs of adder 5 flip -> 2
    apply(12'hA7D, 12'h3D0); wait_idle();
    // R3: only carries of all adders flip -> 12
    apply(12'hA7D, 12'hC2F); wait_idle();
    // R4: all outputs flip -> 24, maximum
    apply(~12'hA7D, ~12'hC2F); wait_idle();

    // R8/R5/R9: strobes during busy are ignored
    apply(12'h000, 12'h000);
    held = score;
    for (int k = 0; k < 4; k++) begin
      sample_valid = 1'b1; fa_sum = 12'hFFF; fa_cout = 12'hFFF;
      @(negedge clk);
      check(score == held, "R9 score held while busy", int'(score), int'(held));
    end
    sample_valid = 1'b0;
    wait_idle();
    // history still all-zero: one flip on adder 3 sum -> 1
    apply(12'h008, 12'h000); wait_idle();
    check(score == SCORE_W'(1), "R5 history from accepted op", int'(score), 1);

    // random patterns
    for (int k = 0; k < 20; k++) begin
      apply(NUM_FA'($urandom), NUM_FA'($urandom));
      wait_idle();
    end

    // R2 again after mid-run reset
    rst_n = 1'b0; @(negedge clk);
    check(score == '0 && activity == '0, "R1 mid-run reset", int'(score), 0);
    rst_n = 1'b1; m_primed = 0; exp_q.delete();
    @(negedge clk);
    apply(12'hFFF, 12'h000); wait_idle();
    apply(12'h000, 12'h000); wait_idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule